// File: doc/BRIEF.md
# Physical Register Rename Unit

This block maps logical register numbers onto a larger shared pool of physical registers. It holds three pieces of state. The speculative map gives the newest physical name of every logical register. The committed map gives the name each logical register has at the commit point. The free pool is a bitmap of unused physical registers. For each instruction that writes a register, the block hands out a fresh physical tag and returns the tag it replaces, so that the tag can be kept with the instruction until commit. Source operands are looked up in the speculative map, so a consumer always reads the tag of its newest in-flight producer.

A commit only updates the committed map and returns the replaced tag to the pool; no register data moves. A flush discards all speculation. The speculative map is reloaded from the committed map, and the free pool is rebuilt as every register the committed map does not reference. Instructions without a destination, such as branches and stores, pass through without taking a tag. A request that needs a tag is stalled while the pool is empty.

Top module: `phys_rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical tag i in both maps (tags numbered from 0), and exactly tags 32 to 63 are free.
- R2: A rename with a destination receives the lowest-numbered free tag on `rn_dst_tag`, and that tag is not handed out again until it is released.
- R3: Source tags are read from the speculative map, so a source naming a logical register written by an earlier accepted rename gets that rename's new tag from the following cycle on.
- R4: A commit writes `cm_new_tag` into the committed map entry for `cm_dst`, and this becomes visible when a later flush reloads the speculative map.
- R5: A commit puts `cm_prev_tag` back in the free pool, where it can be allocated from the next cycle on.
- R6: A request with `rn_dst_en` low allocates nothing and leaves the speculative map unchanged.
- R7: `rn_stall` is high exactly when a valid request needs a destination and no tag is free. A stalled request changes no state, and a request without a destination is not stalled when the pool is empty.
- R8: `rn_prev_tag` gives the current speculative mapping of `rn_dst`, which is the tag replaced by the rename.
- R9: A flush reloads the speculative map from the committed map, including a commit in the same cycle. It makes free exactly the tags the committed map does not reference, and it drops any rename presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 1 | Rename request present |
| rn_src_a | input | 5 | First source logical register |
| rn_src_b | input | 5 | Second source logical register |
| rn_dst_en | input | 1 | Request writes a destination |
| rn_dst | input | 5 | Destination logical register |
| rn_stall | output | 1 | Request cannot proceed, no free tag |
| rn_src_a_tag | output | 6 | Physical tag of first source |
| rn_src_b_tag | output | 6 | Physical tag of second source |
| rn_dst_tag | output | 6 | Newly allocated destination tag |
| rn_prev_tag | output | 6 | Tag the destination mapped to before |
| cm_valid | input | 1 | Commit of a register-writing instruction |
| cm_dst | input | 5 | Committed logical destination |
| cm_new_tag | input | 6 | Tag that becomes committed |
| cm_prev_tag | input | 6 | Tag released by the commit |
| flush | input | 1 | Discard all speculative state |

## Verification
The hardest state to reach from the ports is a full pool, and the stall behaviour that comes with it. Reaching it takes thirty-two back-to-back allocations with no commits, and the bench checks each handed-out tag on the way. Once the pool is empty, it presents a stalled request and then a source read of the stalled logical register, which shows that the map did not move. A second hard case is a flush in the same cycle as a commit and a rename. Afterwards the bench reads the maps back through source lookups and reads the rebuilt pool through the next allocated tag.

// File: rtl/rename_pkg.sv
package rename_pkg;
   localparam int DEF_LOG_REGS  = 32;
   localparam int DEF_PHYS_REGS = 64;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
   parameter int N_ENT = 32,
   parameter int TAG_W = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [$clog2(N_ENT)-1:0]     wr_idx,
   input  logic [TAG_W-1:0]             wr_tag,
   input  logic                         restore_en,
   input  logic [N_ENT-1:0][TAG_W-1:0]  restore_map,
   output logic [N_ENT-1:0][TAG_W-1:0]  map_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_ENT; i++) map_q[i] <= TAG_W'(i);
      end else if (restore_en) begin
         map_q <= restore_map;
      end else if (wr_en) begin
         map_q[wr_idx] <= wr_tag;
      end
   end
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
   parameter int N_PHYS    = 64,
   parameter int N_LOG     = 32,
   parameter bit LOW_FIRST = 1'b1,
   localparam int TAG_W    = $clog2(N_PHYS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         alloc_en,
   input  logic                         rel_en,
   input  logic [TAG_W-1:0]             rel_tag,
   input  logic                         restore_en,
   input  logic [N_LOG-1:0][TAG_W-1:0]  restore_map,
   output logic [N_PHYS-1:0]            free_q,
   output logic                         empty,
   output logic [TAG_W-1:0]             pick_tag
);
   localparam logic [N_PHYS-1:0] RESET_VEC = {{(N_PHYS-N_LOG){1'b1}}, {N_LOG{1'b0}}};

   logic [N_PHYS-1:0] live;
   logic [N_PHYS-1:0] free_d;

   assign empty = (free_q == '0);

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            pick_tag = '0;
            for (int i = N_PHYS-1; i >= 0; i--)
               if (free_q[i]) pick_tag = TAG_W'(i);
         end
      end else begin : g_high
         always_comb begin
            pick_tag = '0;
            for (int i = 0; i < N_PHYS; i++)
               if (free_q[i]) pick_tag = TAG_W'(i);
         end
      end
   endgenerate

   always_comb begin
      live = '0;
      for (int i = 0; i < N_LOG; i++) live[restore_map[i]] = 1'b1;
   end

   always_comb begin
      free_d = free_q;
      if (alloc_en) free_d[pick_tag] = 1'b0;
      if (rel_en)   free_d[rel_tag]  = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          free_q <= RESET_VEC;
      else if (restore_en) free_q <= ~live;
      else                 free_q <= free_d;
   end
endmodule

// File: rtl/phys_rename_unit.sv
module phys_rename_unit
   import rename_pkg::*;
#(
   parameter int N_LOG     = DEF_LOG_REGS,
   parameter int N_PHYS    = DEF_PHYS_REGS,
   parameter bit LOW_FIRST = 1'b1,
   localparam int LOG_W    = $clog2(N_LOG),
   localparam int TAG_W    = $clog2(N_PHYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rn_valid,
   input  logic [LOG_W-1:0] rn_src_a,
   input  logic [LOG_W-1:0] rn_src_b,
   input  logic             rn_dst_en,
   input  logic [LOG_W-1:0] rn_dst,
   output logic             rn_stall,
   output logic [TAG_W-1:0] rn_src_a_tag,
   output logic [TAG_W-1:0] rn_src_b_tag,
   output logic [TAG_W-1:0] rn_dst_tag,
   output logic [TAG_W-1:0] rn_prev_tag,
   input  logic             cm_valid,
   input  logic [LOG_W-1:0] cm_dst,
   input  logic [TAG_W-1:0] cm_new_tag,
   input  logic [TAG_W-1:0] cm_prev_tag,
   input  logic             flush
);
   generate
      if (N_PHYS <= N_LOG) begin : g_bad_size
         $error("physical pool must exceed logical register count");
      end
      if ((1 << LOG_W) != N_LOG) begin : g_bad_log
         $error("logical register count must be a power of two");
      end
   endgenerate

   logic [N_LOG-1:0][TAG_W-1:0] spec_q;
   logic [N_LOG-1:0][TAG_W-1:0] arch_q;
   logic [N_LOG-1:0][TAG_W-1:0] arch_next;
   logic [N_PHYS-1:0]           free_q;
   logic                        pool_empty;
   logic [TAG_W-1:0]            pick_tag;
   logic                        alloc_fire;

   assign rn_stall     = rn_valid & rn_dst_en & pool_empty;
   assign alloc_fire   = rn_valid & rn_dst_en & ~pool_empty & ~flush;
   assign rn_src_a_tag = spec_q[rn_src_a];
   assign rn_src_b_tag = spec_q[rn_src_b];
   assign rn_prev_tag  = spec_q[rn_dst];
   assign rn_dst_tag   = pick_tag;

   always_comb begin
      arch_next = arch_q;
      if (cm_valid) arch_next[cm_dst] = cm_new_tag;
   end

   rn_map_table #(.N_ENT(N_LOG), .TAG_W(TAG_W)) u_spec (
      .clk(clk), .rst_n(rst_n),
      .wr_en(alloc_fire), .wr_idx(rn_dst), .wr_tag(pick_tag),
      .restore_en(flush), .restore_map(arch_next),
      .map_q(spec_q)
   );

   rn_map_table #(.N_ENT(N_LOG), .TAG_W(TAG_W)) u_arch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cm_valid), .wr_idx(cm_dst), .wr_tag(cm_new_tag),
      .restore_en(1'b0), .restore_map('0),
      .map_q(arch_q)
   );

   rn_free_pool #(.N_PHYS(N_PHYS), .N_LOG(N_LOG), .LOW_FIRST(LOW_FIRST)) u_pool (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(alloc_fire),
      .rel_en(cm_valid), .rel_tag(cm_prev_tag),
      .restore_en(flush), .restore_map(arch_next),
      .free_q(free_q), .empty(pool_empty), .pick_tag(pick_tag)
   );
endmodule

// File: rtl/rename_checker.sv
module rename_checker #(
   parameter int N_LOG  = 32,
   parameter int N_PHYS = 64,
   localparam int LOG_W = $clog2(N_LOG),
   localparam int TAG_W = $clog2(N_PHYS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rn_valid,
   input logic              rn_dst_en,
   input logic [LOG_W-1:0]  rn_dst,
   input logic [LOG_W-1:0]  rn_src_a,
   input logic [TAG_W-1:0]  rn_src_a_tag,
   input logic [TAG_W-1:0]  rn_dst_tag,
   input logic              rn_stall,
   input logic              cm_valid,
   input logic [TAG_W-1:0]  cm_prev_tag,
   input logic              flush,
   input logic [N_PHYS-1:0] free_vec
);
   logic fire;
   assign fire = rn_valid & rn_dst_en & ~rn_stall & ~flush;

   AST_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !free_vec[$past(rn_dst_tag)]); // R2
   AST_SOURCE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (rn_src_a != $past(rn_dst)) || (rn_src_a_tag == $past(rn_dst_tag))); // R3
   AST_COMMIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_valid && !flush) |=> free_vec[$past(cm_prev_tag)]); // R5
   AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      rn_stall |-> (free_vec == '0)); // R7
   AST_FLUSH_POOL: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ($countones(free_vec) == N_PHYS - N_LOG)); // R9
endmodule

bind phys_rename_unit rename_checker #(.N_LOG(N_LOG), .N_PHYS(N_PHYS)) u_chk (
   .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_dst_en(rn_dst_en),
   .rn_dst(rn_dst), .rn_src_a(rn_src_a), .rn_src_a_tag(rn_src_a_tag),
   .rn_dst_tag(rn_dst_tag), .rn_stall(rn_stall), .cm_valid(cm_valid),
   .cm_prev_tag(cm_prev_tag), .flush(flush), .free_vec(free_q)
);

// File: tb/tb_phys_rename_unit.sv
module tb_phys_rename_unit;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       rn_valid, rn_dst_en, cm_valid, flush;
   logic [4:0] rn_src_a, rn_src_b, rn_dst, cm_dst;
   logic [5:0] cm_new_tag, cm_prev_tag;
   logic       rn_stall;
   logic [5:0] rn_src_a_tag, rn_src_b_tag, rn_dst_tag, rn_prev_tag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic       g_stall;
   logic [5:0] g_a, g_b, g_d, g_p;

   always #10 clk = ~clk;

   phys_rename_unit dut (.*);

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input logic rv, input int a, input int b, input logic de, input int d,
                      input logic cv, input int cd, input int cn, input int cp, input logic fl);
      @(negedge clk);
      rn_valid = rv; rn_src_a = 5'(a); rn_src_b = 5'(b); rn_dst_en = de; rn_dst = 5'(d);
      cm_valid = cv; cm_dst = 5'(cd); cm_new_tag = 6'(cn); cm_prev_tag = 6'(cp); flush = fl;
      #1;
      g_stall = rn_stall; g_a = rn_src_a_tag; g_b = rn_src_b_tag; g_d = rn_dst_tag; g_p = rn_prev_tag;
      @(posedge clk); #1;
      rn_valid = 0; cm_valid = 0; flush = 0;
   endtask

   task automatic ren(input int a, input int b, input int d);
      cyc(1, a, b, 1, d, 0, 0, 0, 0, 0);
   endtask

   task automatic look(input int a, input int b, input int d);
      cyc(0, a, b, 0, d, 0, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      rst_n = 0; rn_valid = 0; cm_valid = 0; flush = 0; rn_dst_en = 0;
      rn_src_a = 0; rn_src_b = 0; rn_dst = 0; cm_dst = 0; cm_new_tag = 0; cm_prev_tag = 0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1;
   endtask

   task automatic t_reset();
      do_reset();
      look(5, 31, 7);
      chk("R1 src a", g_a, 5); chk("R1 src b", g_b, 31);
      chk("R1 prev", g_p, 7); chk("R1 first free", g_d, 32);
      chk("R1 no stall", g_stall, 0);
   endtask

   task automatic t_chain();
      do_reset();
      ren(1, 2, 1);
      chk("R2 tag", g_d, 32); chk("R8 prev", g_p, 1); chk("R3 src", g_a, 1);
      ren(1, 3, 2);
      chk("R3 forwarded", g_a, 32); chk("R2 next tag", g_d, 33); chk("R8 prev r2", g_p, 2);
      ren(2, 1, 1);
      chk("R3 src a", g_a, 33); chk("R3 src b", g_b, 32);
      chk("R2 third", g_d, 34); chk("R8 prev chain", g_p, 32);
   endtask

   task automatic t_nodest();
      do_reset();
      cyc(1, 4, 4, 0, 4, 0, 0, 0, 0, 0);
      ren(4, 0, 4);
      chk("R6 map kept", g_a, 4); chk("R6 no alloc", g_d, 32); chk("R6 prev", g_p, 4);
   endtask

   task automatic t_stall();
      do_reset();
      for (int i = 0; i < 32; i++) begin
         ren(0, 0, i % 32);
         chk("R2 fill", g_d, 32 + i);
      end
      cyc(1, 0, 0, 1, 5, 0, 0, 0, 0, 0);
      chk("R7 stall", g_stall, 1);
      look(5, 0, 0);
      chk("R7 map held", g_a, 37);
      cyc(1, 5, 0, 0, 5, 0, 0, 0, 0, 0);
      chk("R7 no-dest not stalled", g_stall, 0);
   endtask

   task automatic t_release();
      do_reset();
      ren(0, 0, 3);
      ren(0, 0, 3);
      chk("R8 prev second", g_p, 32);
      cyc(0, 0, 0, 0, 0, 1, 3, 32, 3, 0);
      cyc(0, 0, 0, 0, 0, 1, 3, 33, 32, 0);
      ren(0, 0, 0);
      chk("R5 released low", g_d, 3);
      ren(0, 0, 1);
      chk("R5 released second", g_d, 32);
   endtask

   task automatic t_commit_flush();
      do_reset();
      ren(0, 0, 3);
      cyc(0, 0, 0, 0, 0, 1, 3, 32, 3, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      look(3, 9, 0);
      chk("R4 committed map", g_a, 32); chk("R4 other entry", g_b, 9);
      ren(0, 0, 9);
      chk("R9 pool rebuilt", g_d, 3);
   endtask

   task automatic t_flush();
      do_reset();
      ren(0, 0, 1);
      ren(0, 0, 2);
      cyc(1, 0, 0, 1, 8, 0, 0, 0, 0, 1);
      look(1, 2, 8);
      chk("R9 map 1", g_a, 1); chk("R9 map 2", g_b, 2);
      chk("R9 rename dropped", g_p, 8); chk("R9 pool reset", g_d, 32);
      ren(0, 0, 6);
      ren(0, 0, 7);
      cyc(0, 0, 0, 0, 0, 1, 6, 32, 6, 1);
      look(6, 7, 0);
      chk("R9 same-cycle commit", g_a, 32); chk("R9 discarded", g_b, 7);
      chk("R9 freed prev", g_d, 6);
   endtask

   initial begin
      t_reset();
      t_chain();
      t_nodest();
      t_stall();
      t_release();
      t_commit_flush();
      t_flush();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule